// File: doc/BRIEF.md
# Alternate Pulse Gate

This block watches a single pulse stream and lets every second pulse through to its output, whole and unshortened, while the pulses in between are suppressed. Pulse widths and the gaps between pulses may vary freely, as long as each high and each low phase is long enough for the clock to see it. A typical use is halving the rate of a strobe or event line without changing the shape of the strobes that remain.

The pulse input is first brought into the clock domain by a synchroniser and is then sampled once per clock. The stream is followed by a four-state Moore machine: idle with the line low, inside a pulse that is held back, in the gap after it, and inside a pulse that is passed on. The two state bits use a Gray code, so every legal step flips a single bit. Each bit is kept in its own set/clear stage driven by its own excitation equations. The output is a flop fed only from the state bits, so no decoding glitch can reach it.

Top module: `alt_pulse_gate`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state bits become 00 (idle) and `pulse_out` becomes 0; all synchroniser stages clear to 0.
- R2: A change on `pulse_in` that is set up before rising edge n shows on `pulse_out` just after rising edge n+3: two synchroniser stages, one state update and one output register.
- R3: Counting pulses from reset, `pulse_out` is high for exactly the cycles of every even-numbered pulse (2nd, 4th, ...). The output pulse has the same width as the input pulse and is delayed as given in R2.
- R4: Odd-numbered pulses (1st, 3rd, ...) leave `pulse_out` at 0 for their whole duration and for the gap that follows.
- R5: The state bits {y1,y0} use the code idle = 00, held pulse = 01, gap = 11, passed pulse = 10. Between two clock edges with no reset, at most one state bit changes.
- R6: For each state bit, its set and clear terms are never 1 in the same cycle. When both are 0, the bit keeps its value. The equations are: y0 set = ~y1 & x, y0 clear = y1 & x, y1 set = y0 & ~x, y1 clear = ~y0 & ~x, where x is the synchronised input.
- R7: While the synchronised input holds its value, the state does not change after the first update that follows the value's arrival.
- R8: `pulse_out` is the registered flag "state was 10 in the previous cycle". It is 1 in no other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Pulse stream, may be asynchronous to `clk` |
| pulse_out | output | 1 | Every second input pulse, registered |

## Verification
Random pulse trains with widths and gaps from one to twelve cycles check that the parity of the passed pulses is correct under irregular timing, and that widths are kept unchanged. Trains of single-cycle pulses and gaps test the fastest legal stream, where every cycle carries a state change. One very long pulse shows that the machine holds its state while the input is steady. A reset in the middle of a passed pulse checks that counting restarts, so that the next pulse after the reset is held back again.

// File: rtl/alt_gate_pkg.sv
package alt_gate_pkg;

    localparam int NUM_VARS = 2;

    // Gray-coded states: {y1, y0}
    typedef enum logic [NUM_VARS-1:0] {
        ST_IDLE = 2'b00,
        ST_HELD = 2'b01,
        ST_GAP  = 2'b11,
        ST_PASS = 2'b10
    } gate_state_e;

    typedef struct packed {
        logic set;
        logic clr;
    } sr_pair_t;

    typedef sr_pair_t [NUM_VARS-1:0] sr_bank_t;

    // Excitation terms for each state variable given present state and input.
    function automatic sr_bank_t excite(input logic [NUM_VARS-1:0] y, input logic x);
        sr_bank_t b;
        b[0].set = ~y[1] &  x;
        b[0].clr =  y[1] &  x;
        b[1].set =  y[0] & ~x;
        b[1].clr = ~y[0] & ~x;
        return b;
    endfunction

    // Set/clear stage update: hold when neither term is active.
    function automatic logic sr_next(input logic q, input sr_pair_t p);
        if (p.set) begin
            return 1'b1;
        end
        if (p.clr) begin
            return 1'b0;
        end
        return q;
    endfunction

    function automatic logic is_passing(input gate_state_e s);
        return s == ST_PASS;
    endfunction

endpackage

// File: rtl/alt_gate_sync.sv
module alt_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/alt_gate_excite.sv
module alt_gate_excite
    import alt_gate_pkg::*;
(
    input  logic [NUM_VARS-1:0] y,
    input  logic                x,
    output logic [NUM_VARS-1:0] set_v,
    output logic [NUM_VARS-1:0] clr_v
);
    sr_bank_t bank;

    always_comb begin
        bank = excite(y, x);
        for (int i = 0; i < NUM_VARS; i++) begin
            set_v[i] = bank[i].set;
            clr_v[i] = bank[i].clr;
        end
    end
endmodule

// File: rtl/alt_gate_srbit.sv
module alt_gate_srbit
    import alt_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    sr_pair_t pair;

    always_comb begin
        pair.set = set_i;
        pair.clr = clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= sr_next(q, pair);
        end
    end
endmodule

// File: rtl/alt_gate_outreg.sv
module alt_gate_outreg
    import alt_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  gate_state_e state,
    output logic        z
);
    always_ff @(posedge clk) begin
        if (rst) begin
            z <= 1'b0;
        end else begin
            z <= is_passing(state);
        end
    end
endmodule

// File: rtl/alt_pulse_gate.sv
module alt_pulse_gate
    import alt_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic pulse_out
);
    logic                x_sync;
    logic [NUM_VARS-1:0] state_bits;
    logic [NUM_VARS-1:0] set_v;
    logic [NUM_VARS-1:0] clr_v;
    gate_state_e         state;

    alt_gate_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pulse_in),
        .q   (x_sync)
    );

    alt_gate_excite excite_i (
        .y     (state_bits),
        .x     (x_sync),
        .set_v (set_v),
        .clr_v (clr_v)
    );

    for (genvar g = 0; g < NUM_VARS; g++) begin : g_var
        alt_gate_srbit bit_i (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q     (state_bits[g])
        );
    end

    assign state = gate_state_e'(state_bits);

    alt_gate_outreg out_i (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .z     (pulse_out)
    );
endmodule

// File: rtl/alt_pulse_gate_chk.sv
module alt_pulse_gate_chk
    import alt_gate_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                x,
    input logic [NUM_VARS-1:0] state,
    input logic [NUM_VARS-1:0] set_v,
    input logic [NUM_VARS-1:0] clr_v,
    input logic                z
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE) && !z);

    // R5
    a_r5_single_bit_step: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $countones(state ^ $past(state)) <= 1);

    // R6
    a_r6_set_clr_exclusive: assert property (@(posedge clk) disable iff (rst)
        (set_v & clr_v) == '0);

    // R7
    a_r7_hold_when_steady: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && x == $past(x)) |=> $stable(state));

    // R8
    a_r8_out_from_state: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (z == ($past(state) == ST_PASS)));
endmodule

bind alt_pulse_gate alt_pulse_gate_chk chk_i (
    .clk   (clk),
    .rst   (rst),
    .x     (x_sync),
    .state (state_bits),
    .set_v (set_v),
    .clr_v (clr_v),
    .z     (pulse_out)
);

// File: tb/alt_pulse_gate_tb.sv
module alt_pulse_gate_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse_in = 1'b0;
    logic pulse_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state: gated flag history and pulse count
    logic [3:0] hist = '0;
    int unsigned pulse_cnt = 0;
    logic prev_in = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    alt_pulse_gate dut_i (
        .clk       (clk),
        .rst       (rst),
        .pulse_in  (pulse_in),
        .pulse_out (pulse_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: pulse_out=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // Expected gated value of one input sample (R3/R4 parity rule)
    function automatic logic gated_of(input logic v, input int unsigned cnt);
        return v && (cnt != 0) && (cnt % 2 == 0);
    endfunction

    // One cycle: check output against the sample from four drives ago (R2),
    // then drive a new input value.
    task automatic step(input logic v, input string req);
        @(negedge clk);
        check(pulse_out, hist[3], req);
        pulse_in = v;
        if (v && !prev_in) begin
            pulse_cnt++;
        end
        prev_in = v;
        hist = {hist[2:0], gated_of(v, pulse_cnt)};
    endtask

    task automatic pulse(input int hi, input int lo, input string req);
        for (int i = 0; i < hi; i++) step(1'b1, req);
        for (int i = 0; i < lo; i++) step(1'b0, req);
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        pulse_in = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            // R1: output cleared while reset is applied
            if (i > 0) check(pulse_out, 1'b0, "R1");
        end
        rst = 1'b0;
        hist = '0;
        pulse_cnt = 0;
        prev_in = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset(4);
        // R1: idle after reset with no input
        for (int i = 0; i < 6; i++) step(1'b0, "R1");

        // R2 R3 R4: directed pair, exact latency
        pulse(3, 4, "R4 first pulse held");
        pulse(5, 6, "R2 R3 second pulse passed");

        // R5 R6: single-cycle pulses and gaps, a state change every cycle
        for (int i = 0; i < 10; i++) pulse(1, 1, "R5 R6 fastest stream");
        pulse(0, 6, "R3");

        // R7: very long pulse held steady
        pulse(40, 8, "R7 long held pulse");
        pulse(40, 8, "R7 R8 long passed pulse");

        // Random widths and gaps
        for (int n = 0; n < 300; n++) begin
            pulse(int'($urandom_range(1, 12)), int'($urandom_range(1, 12)), "R3 R4 random train");
        end
        pulse(0, 6, "R3");

        // R1: reset in the middle of a passed pulse, parity restarts
        pulse(4, 4, "R4");
        pulse(6, 0, "R3");
        do_reset(3);
        for (int i = 0; i < 4; i++) step(1'b0, "R1 after mid-pulse reset");
        pulse(5, 5, "R1 R4 first pulse after reset held");
        pulse(5, 6, "R3 second pulse after reset passed");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule